// File: doc/BRIEF.md
# Rename Map Checkpoint Table

The block holds a pool of snapshot slots for the speculative register rename map, so that a branch misprediction can be undone in one step instead of by walking the reorder buffer. Each branch or jump that reaches dispatch asks for a slot. The rename stage presents the map as it stands after that branch's own destination register has been renamed, and the block stores it in the granted slot. Slots are kept in age order in a circular queue. The oldest slot is released when its branch commits. A misprediction names the owning slot. The block returns that slot's map one cycle later and releases the owner together with every younger slot. A full pipeline flush releases every slot.

When every slot is occupied, a new branch at dispatch gets a stall instead of a grant. The exception is a commit in the same cycle: that frees the oldest slot and lets the new branch take a slot without waiting. A counter accumulates the cycles spent in this stall. When the slot count is set to zero, checkpointing is disabled. No slot is ever granted, no stall is raised, and every restore reports that no checkpoint exists, so the core falls back to rebuilding the map.

Top module: `ckpt_table`

## Requirements
- R1: After reset the table is empty (`used_o` = 0), `restore_valid_o` is 0 and `stall_cycles_o` is 0.
- R2: A request with no flush and no mispredict, made while fewer than NUM_SLOTS slots are used, is granted in the same cycle. Granted tags run upward modulo NUM_SLOTS from the oldest live slot, so a new tag equals (oldest + used) mod NUM_SLOTS.
- R3: The map presented with a granted request is the exact map returned by a later restore of that slot, all ARCH_REGS fields of PREG_W bits each, with field i at bits [i*PREG_W +: PREG_W].
- R4: A request made while all NUM_SLOTS slots are used, with no commit in that cycle, raises `alloc_stall_o` and gets no grant. `used_o` never exceeds NUM_SLOTS.
- R5: A request made while the table is full, in the same cycle as a commit, is granted without a stall, and `used_o` is unchanged.
- R6: `commit_i` releases the oldest slot when at least one slot is used, so `used_o` drops by one on the next cycle.
- R7: A mispredict naming a live slot makes `restore_valid_o` and `restore_hit_o` high on the next cycle. It releases the owner and all younger slots, so `used_o` becomes (tag − oldest) mod NUM_SLOTS, less one if a commit in the same cycle released an oldest slot other than the owner.
- R8: In a mispredict cycle a request is neither granted nor stalled.
- R9: `flush_i` releases every slot, so `used_o` is 0 on the next cycle.
- R10: `stall_cycles_o` increases by one for each cycle in which `alloc_stall_o` is high, and saturates at its maximum value.
- R11: With NUM_SLOTS = 0 no request is ever granted or stalled. Every mispredict gives `restore_valid_o` high with `restore_hit_o` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Branch or jump at dispatch asks for a slot |
| alloc_map_i | input | ARCH_REGS*PREG_W | Rename map after the branch's own destination rename |
| alloc_gnt_o | output | 1 | Slot granted this cycle |
| alloc_stall_o | output | 1 | Table full; rename must hold |
| alloc_tag_o | output | TAG_W | Granted slot index |
| commit_i | input | 1 | Oldest owning branch commits |
| flush_i | input | 1 | Full pipeline flush; release all slots |
| mispredict_i | input | 1 | Misprediction of the branch owning `mispredict_tag_i` |
| mispredict_tag_i | input | TAG_W | Owner slot of the mispredicted branch |
| restore_valid_o | output | 1 | Restore result present (one cycle after mispredict) |
| restore_hit_o | output | 1 | A checkpoint was available for the restore |
| restore_map_o | output | ARCH_REGS*PREG_W | Restored rename map |
| used_o | output | USED_W | Number of occupied slots |
| stall_cycles_o | output | STALL_CNT_W | Cycles stalled on a full table |

## Verification
The bench sweeps every occupancy of a four-slot table against every owner position within it. Before each case it rotates the oldest pointer so that mispredicts wrap around the ring. This catches a release count that ignores wrap-around, or that frees the owner's elders; such a design would then hand out a tag other than the owner's on the next request. Full-table requests are tried both with and without a same-cycle commit. A design that stalls on the combined case, or that grants past capacity, shows a wrong grant, stall or stall count. A mispredict is combined with a request and with a commit to expose wrong priority. A zero-slot instance runs in parallel and must never grant and must always report a restore with no checkpoint.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef enum logic [1:0] {
    OP_NORM  = 2'd0,
    OP_MISP  = 2'd1,
    OP_FLUSH = 2'd2
  } ckpt_op_e;

  // forward distance from 'from' to 'to' on a ring of n entries
  function automatic int ring_dist(input int from, input int to, input int n);
    int d;
    d = to - from;
    if (d < 0) d = d + n;
    return d;
  endfunction

endpackage

// File: rtl/ckpt_ring_ctrl.sv
module ckpt_ring_ctrl
  import ckpt_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  input  logic             commit_i,
  input  logic             flush_i,
  input  logic             mispredict_i,
  input  logic [IDX_W-1:0] mispredict_tag_i,
  output logic             alloc_gnt_o,
  output logic             alloc_stall_o,
  output logic [IDX_W-1:0] alloc_tag_o,
  output logic [CNT_W-1:0] used_o
);

  logic [IDX_W-1:0] head_q, head_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, empty, commit_ok, blocked, drop;
  ckpt_op_e         op;
  int               tail_i, owner_d;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] x);
    return (int'(x) == SLOTS - 1) ? '0 : x + IDX_W'(1);
  endfunction

  assign full      = (cnt_q == CNT_W'(SLOTS));
  assign empty     = (cnt_q == '0);
  assign commit_ok = commit_i && !empty;
  assign blocked   = flush_i || mispredict_i;

  always_comb begin
    tail_i = int'(head_q) + int'(cnt_q);
    if (tail_i >= SLOTS) tail_i = tail_i - SLOTS;
  end

  assign owner_d = ring_dist(int'(head_q), int'(mispredict_tag_i), SLOTS);

  assign alloc_tag_o   = IDX_W'(tail_i);
  assign alloc_gnt_o   = alloc_req_i && !blocked && (!full || commit_ok);
  assign alloc_stall_o = alloc_req_i && !blocked && full && !commit_ok;
  assign used_o        = cnt_q;

  always_comb begin
    if (flush_i)           op = OP_FLUSH;
    else if (mispredict_i) op = OP_MISP;
    else                   op = OP_NORM;
  end

  // a commit beside a mispredict only retires a slot older than the owner
  assign drop = commit_ok && (owner_d != 0);

  always_comb begin
    head_d = head_q;
    cnt_d  = cnt_q;
    unique case (op)
      OP_FLUSH: cnt_d = '0;
      OP_MISP: begin
        if (drop) head_d = step(head_q);
        cnt_d = CNT_W'(owner_d - int'(drop));
      end
      default: begin
        if (commit_ok) head_d = step(head_q);
        cnt_d = cnt_q + CNT_W'(alloc_gnt_o) - CNT_W'(commit_ok);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SLOTS));

  assert_stall_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_stall_o && alloc_gnt_o));

  assert_full_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o && full) |-> commit_i);

  assert_owner_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispredict_i && !flush_i) |-> (owner_d < int'(cnt_q)));

  assert_misp_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |-> (!alloc_gnt_o && !alloc_stall_o));

  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (used_o == '0));

endmodule

// File: rtl/ckpt_snap_store.sv
module ckpt_snap_store #(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5,
  parameter int MAP_W = 224
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [MAP_W-1:0] wr_map_i,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [MAP_W-1:0] rd_map_o
);

  logic [MAP_W-1:0] slot_q [SLOTS];
  logic [MAP_W-1:0] rd_map_q;
  logic             rd_valid_q;

  always_ff @(posedge clk_i) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(s))) slot_q[s] <= wr_map_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_map_q   <= '0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_map_q <= slot_q[rd_idx_i];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_map_o   = rd_map_q;

  assert_restore_next_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  assert_no_wr_on_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));

endmodule

// File: rtl/ckpt_stall_cnt.sv
module ckpt_stall_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  assert_stall_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o != '1) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));

endmodule

// File: rtl/ckpt_table.sv
module ckpt_table #(
  parameter  int NUM_SLOTS   = 32,
  parameter  int ARCH_REGS   = 32,
  parameter  int PREG_W      = 7,
  parameter  int STALL_CNT_W = 16,
  localparam int MAP_W       = ARCH_REGS * PREG_W,
  localparam int TAG_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int USED_W      = (NUM_SLOTS > 0) ? $clog2(NUM_SLOTS + 1) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   alloc_req_i,
  input  logic [MAP_W-1:0]       alloc_map_i,
  output logic                   alloc_gnt_o,
  output logic                   alloc_stall_o,
  output logic [TAG_W-1:0]       alloc_tag_o,
  input  logic                   commit_i,
  input  logic                   flush_i,
  input  logic                   mispredict_i,
  input  logic [TAG_W-1:0]       mispredict_tag_i,
  output logic                   restore_valid_o,
  output logic                   restore_hit_o,
  output logic [MAP_W-1:0]       restore_map_o,
  output logic [USED_W-1:0]      used_o,
  output logic [STALL_CNT_W-1:0] stall_cycles_o
);

  if (NUM_SLOTS > 0) begin : g_on
    logic gnt, stall;

    ckpt_ring_ctrl #(
      .SLOTS (NUM_SLOTS),
      .IDX_W (TAG_W),
      .CNT_W (USED_W)
    ) u_ring (
      .clk_i            (clk_i),
      .rst_ni           (rst_ni),
      .alloc_req_i      (alloc_req_i),
      .commit_i         (commit_i),
      .flush_i          (flush_i),
      .mispredict_i     (mispredict_i),
      .mispredict_tag_i (mispredict_tag_i),
      .alloc_gnt_o      (gnt),
      .alloc_stall_o    (stall),
      .alloc_tag_o      (alloc_tag_o),
      .used_o           (used_o)
    );

    ckpt_snap_store #(
      .SLOTS (NUM_SLOTS),
      .IDX_W (TAG_W),
      .MAP_W (MAP_W)
    ) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (gnt),
      .wr_idx_i   (alloc_tag_o),
      .wr_map_i   (alloc_map_i),
      .rd_en_i    (mispredict_i),
      .rd_idx_i   (mispredict_tag_i),
      .rd_valid_o (restore_valid_o),
      .rd_map_o   (restore_map_o)
    );

    ckpt_stall_cnt #(
      .CNT_W (STALL_CNT_W)
    ) u_stall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (stall),
      .cnt_o  (stall_cycles_o)
    );

    assign alloc_gnt_o   = gnt;
    assign alloc_stall_o = stall;
    assign restore_hit_o = restore_valid_o;
  end else begin : g_off
    // checkpointing disabled: restores always fall back to a rebuild
    logic rv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rv_q <= 1'b0;
      else         rv_q <= mispredict_i;
    end

    assign alloc_gnt_o     = 1'b0;
    assign alloc_stall_o   = 1'b0;
    assign alloc_tag_o     = '0;
    assign restore_valid_o = rv_q;
    assign restore_hit_o   = 1'b0;
    assign restore_map_o   = '0;
    assign used_o          = '0;
    assign stall_cycles_o  = '0;

    assert_off_restore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mispredict_i |=> (restore_valid_o && !restore_hit_o));
  end

endmodule

// File: tb/sim_ckpt_table.sv
`timescale 1ns/1ps
module sim_ckpt_table;

  localparam int N  = 4;
  localparam int A  = 4;
  localparam int P  = 4;
  localparam int MW = A * P;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req = 0, com = 0, misp = 0, fl = 0;
  logic [1:0]    tag = '0;
  logic [MW-1:0] amap = '0;

  logic          gnt, stall, rv, rh;
  logic [1:0]    atag;
  logic [MW-1:0] rmap;
  logic [2:0]    used;
  logic [SW-1:0] scnt;

  logic          z_gnt, z_stall, z_rv, z_rh;
  logic [0:0]    z_tag, z_used;
  logic [MW-1:0] z_map;
  logic [SW-1:0] z_scnt;

  ckpt_table #(.NUM_SLOTS(N), .ARCH_REGS(A), .PREG_W(P), .STALL_CNT_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .alloc_req_i(req), .alloc_map_i(amap),
    .alloc_gnt_o(gnt), .alloc_stall_o(stall), .alloc_tag_o(atag),
    .commit_i(com), .flush_i(fl), .mispredict_i(misp), .mispredict_tag_i(tag),
    .restore_valid_o(rv), .restore_hit_o(rh), .restore_map_o(rmap),
    .used_o(used), .stall_cycles_o(scnt));

  ckpt_table #(.NUM_SLOTS(0), .ARCH_REGS(A), .PREG_W(P), .STALL_CNT_W(SW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .alloc_req_i(req), .alloc_map_i(amap),
    .alloc_gnt_o(z_gnt), .alloc_stall_o(z_stall), .alloc_tag_o(z_tag),
    .commit_i(com), .flush_i(fl), .mispredict_i(misp), .mispredict_tag_i(tag[0:0]),
    .restore_valid_o(z_rv), .restore_hit_o(z_rh), .restore_map_o(z_map),
    .used_o(z_used), .stall_cycles_o(z_scnt));

  int n_chk = 0, n_fail = 0;
  int m_head = 0, m_cnt = 0, m_stalls = 0, seq = 1;
  logic [MW-1:0] m_maps [N];
  bit done = 0;

  function automatic logic [MW-1:0] map_of(input int k);
    logic [MW-1:0] r;
    for (int a = 0; a < A; a++) r[a*P +: P] = P'(k * 3 + a * 5 + 1);
    return r;
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and checks both phases
  task automatic do_op(input string rq, input bit r, input bit c, input bit m, input int t, input bit f);
    int tail, d;
    bit e_gnt, e_stall, dc;
    logic [MW-1:0] e_map;
    tail = (m_head + m_cnt) % N;
    req = r; com = c; misp = m; tag = 2'(t); fl = f; amap = map_of(seq);
    #1;
    e_gnt   = r && !m && !f && (m_cnt < N || (c && m_cnt > 0));
    e_stall = r && !m && !f && m_cnt == N && !(c && m_cnt > 0);
    chk(rq, "grant", 32'(gnt), 32'(e_gnt));
    chk(rq, "stall", 32'(stall), 32'(e_stall));
    if (e_gnt) chk(rq, "tag", 32'(atag), 32'(tail));
    chk("R11", "zero-slot grant", 32'(z_gnt), 0);
    chk("R11", "zero-slot stall", 32'(z_stall), 0);
    e_map = m_maps[t % N];
    if (f) m_cnt = 0;
    else if (m) begin
      d = (t - m_head + N) % N;
      dc = c && m_cnt > 0 && d != 0;
      m_cnt = d - int'(dc);
      m_head = (m_head + int'(dc)) % N;
    end else begin
      dc = c && m_cnt > 0;
      if (e_gnt) begin m_maps[tail] = amap; seq++; end
      m_head = (m_head + int'(dc)) % N;
      m_cnt = m_cnt + int'(e_gnt) - int'(dc);
    end
    if (e_stall && m_stalls < 255) m_stalls++;
    @(posedge clk);
    @(negedge clk);
    req = 0; com = 0; misp = 0; fl = 0;
    #1;
    chk(rq, "used", 32'(used), 32'(m_cnt));
    chk("R10", "stall cycles", 32'(scnt), 32'(m_stalls));
    chk(rq, "restore valid", 32'(rv), 32'(m));
    if (m) begin
      chk("R7", "restore hit", 32'(rh), 1);
      chk("R3", "restore map", 32'(rmap), 32'(e_map));
    end
    chk("R11", "zero-slot restore valid", 32'(z_rv), 32'(m));
    if (m) chk("R11", "zero-slot restore hit", 32'(z_rh), 0);
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "used", 32'(used), 0);
    chk("R1", "restore valid", 32'(rv), 0);
    chk("R1", "stall cycles", 32'(scnt), 0);
    chk("R1", "zero-slot restore valid", 32'(z_rv), 0);
    @(negedge clk);

    // every occupancy against every owner position, with head rotated
    for (int o = 1; o <= N; o++) begin
      for (int j = 0; j < o; j++) begin
        do_op("R9", 0, 0, 0, 0, 1);
        for (int r = 0; r < (o + j) % N; r++) begin
          do_op("R2", 1, 0, 0, 0, 0);
          do_op("R6", 0, 1, 0, 0, 0);
        end
        for (int k = 0; k < o; k++) do_op("R2", 1, 0, 0, 0, 0);
        do_op("R7", 0, 0, 1, (m_head + j) % N, 0);
        chk("R7", "slots left after mispredict", 32'(used), 32'(j));
        do_op("R2", 1, 0, 0, 0, 0);  // reuses the owner's slot
      end
    end

    // full table behaviour
    do_op("R9", 0, 0, 0, 0, 1);
    for (int k = 0; k < N; k++) do_op("R2", 1, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) do_op("R4", 1, 0, 0, 0, 0);
    chk("R4", "used at capacity", 32'(used), 32'(N));
    do_op("R5", 1, 1, 0, 0, 0);
    chk("R5", "used after commit+alloc", 32'(used), 32'(N));
    do_op("R6", 0, 1, 0, 0, 0);
    chk("R6", "used after commit", 32'(used), 32'(N - 1));

    // mispredict beats a same-cycle request
    do_op("R8", 1, 0, 1, (m_head + 1) % N, 0);
    chk("R8", "used after misp with request", 32'(used), 1);

    // mispredict together with a commit of an older branch
    do_op("R2", 1, 0, 0, 0, 0);
    do_op("R2", 1, 0, 0, 0, 0);
    do_op("R7", 0, 1, 1, (m_head + 2) % N, 0);
    chk("R7", "used after misp with commit", 32'(used), 1);

    // flush from a full table
    for (int k = 0; k < N - 1; k++) do_op("R2", 1, 0, 0, 0, 0);
    do_op("R4", 1, 0, 0, 0, 0);
    do_op("R9", 1, 0, 0, 0, 1);
    chk("R9", "used after flush", 32'(used), 0);
    chk("R10", "final stall cycles", 32'(scnt), 4);

    done = 1;
    report();
  end

endmodule